// File: doc/BRIEF.md
# LCD Power-Up Init Sequencer

This block brings a small colour LCD panel out of reset and configures it. Once the block leaves reset, it holds the panel's reset line low for a timed interval while chip select stays high. It then releases the panel, drives chip select low and sends a fixed, ordered script of command and data bytes. These bytes go to a downstream parallel write-bus engine over a valid/ready byte stream.

The script does the following, in order:
- sets the orientation;
- sets a 160-column by 128-row window;
- selects 16-bit pixels, then pauses;
- wakes the panel, then waits longer;
- switches the display on and opens a memory write.

After that, chip select returns high and a done flag is raised.

A 2-bit panel-type input picks the orientation byte. All waits are whole milliseconds, and their length in cycles comes from a cycles-per-millisecond parameter. A one-cycle start pulse given while done is high runs the whole sequence again, including the panel reset.

Top module: `lcd_init_seq`

## Requirements
- R1: While `rst` is high: `csN` is 1, `panelRstN` is 0, `byteValid` is 0 and `done` is 0.
- R2: After `rst` falls, or after an accepted start pulse, `panelRstN` stays 0 for exactly 20 × CYC_PER_MS cycles, with `csN` held at 1 during that time. It then goes to 1.
- R3: `csN` goes to 0 in the same cycle that `panelRstN` rises. It stays 0 until the last byte has been accepted, and it is 1 from the following cycle on.
- R4: The byte after command 0x36 is data chosen by `panelType`: 1 gives 0x60, 2 gives 0x00, and 0 or 3 give 0xA0.
- R5: The window setup is command 0x2A followed by data 0x00, 0x00, 0x00, 0xA0, then command 0x2B followed by data 0x00, 0x00, 0x00, 0x80.
- R6: Command 0x3A is followed by data 0x05. After that byte is accepted, `byteValid` is 0 (with `csN` low) for exactly 10 × CYC_PER_MS cycles.
- R7: Command 0x11 comes next. After it is accepted, `byteValid` is 0 for exactly 120 × CYC_PER_MS cycles. Then come commands 0x29 and 0x2C.
- R8: A byte is transferred in a cycle where `byteValid` and `byteReady` are both 1. While `byteValid` is 1 and `byteReady` is 0, `byteOut` and `isData` hold their values. `isData` is 0 for a command and 1 for data.
- R9: The script is exactly the 17 bytes of R4–R7 in the order 0x36, orientation, the R5 bytes, 0x3A, 0x05, 0x11, 0x29, 0x2C. Apart from the R6 and R7 waits, `byteValid` is never 0 while `csN` is 0.
- R10: `done` rises in the cycle after 0x2C is accepted and stays high until a start pulse. The start pulse clears `done` in the next cycle.
- R11: A start pulse while `done` is 0 is ignored: the running sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Re-run pulse, accepted only while done |
| panelType | input | 2 | Selects the orientation byte |
| byteReady | input | 1 | Downstream engine accepts the byte |
| byteValid | output | 1 | A byte is offered |
| byteOut | output | 8 | Command or data byte |
| isData | output | 1 | 1 = data byte, 0 = command byte |
| panelRstN | output | 1 | Panel reset, active low |
| csN | output | 1 | Panel chip select, active low |
| done | output | 1 | Sequence complete |

## Verification
A corrupted script index shows up at the port within one handshake, as a wrong or missing byte in the recorded stream. A wrong wait count shows up at the port as a wait gap of the wrong length around the 0x05 and 0x11 bytes. It is measured to the exact cycle. A control state that leaves its phase too early or too late shows up as a reset-low interval other than 20 ms. It can also show as chip select changing level before the first byte or after the last one. Each of these is seen by the end of the affected run.

// File: rtl/lcd_init_pkg.sv
package lcd_init_pkg;

  localparam int RST_MS    = 20;
  localparam int MAX_MS    = 120;
  localparam int LAST_STEP = 16;
  localparam int IDX_W     = $clog2(LAST_STEP + 1);

  typedef enum logic [1:0] {S_RST, S_SEND, S_WAIT, S_DONE} seqState_t;

  typedef struct packed {
    logic loadRst;
    logic loadStep;
    logic advIdx;
    logic clrIdx;
  } seqStrobe_t;

  typedef struct packed {
    logic       isData;
    logic [7:0] val;
    logic [6:0] waitMs;
  } seqStep_t;

  function automatic seqStep_t stepAt(input logic [IDX_W-1:0] idx, input logic [1:0] ptype);
    seqStep_t s;
    s = '{isData: 1'b1, val: 8'h00, waitMs: 7'd0};
    case (idx)
      5'd0:  begin s.isData = 1'b0; s.val = 8'h36; end
      5'd1:  begin
               case (ptype)
                 2'd1:    s.val = 8'h60;
                 2'd2:    s.val = 8'h00;
                 default: s.val = 8'hA0;
               endcase
             end
      5'd2:  begin s.isData = 1'b0; s.val = 8'h2A; end
      5'd6:  s.val = 8'hA0;
      5'd7:  begin s.isData = 1'b0; s.val = 8'h2B; end
      5'd11: s.val = 8'h80;
      5'd12: begin s.isData = 1'b0; s.val = 8'h3A; end
      5'd13: begin s.val = 8'h05; s.waitMs = 7'd10; end
      5'd14: begin s.isData = 1'b0; s.val = 8'h11; s.waitMs = 7'd120; end
      5'd15: begin s.isData = 1'b0; s.val = 8'h29; end
      5'd16: begin s.isData = 1'b0; s.val = 8'h2C; end
      default: s.val = 8'h00;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/lcd_init_dp.sv
module lcd_init_dp
  import lcd_init_pkg::*;
#(
  parameter int CYC_PER_MS = 50000
) (
  input  logic       clk,
  input  logic       rst,
  input  seqStrobe_t strb,
  input  logic [1:0] panelType,
  output logic       cntZero,
  output logic       stepHasWait,
  output logic       lastStep,
  output logic [7:0] byteOut,
  output logic       isData
);

  localparam int RST_CYC = RST_MS * CYC_PER_MS;
  localparam int CNT_W   = $clog2(MAX_MS * CYC_PER_MS + 1);

  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] idx;
  seqStep_t         curStep;

  assign curStep     = stepAt(idx, panelType);
  assign cntZero     = (cnt == '0);
  assign stepHasWait = (curStep.waitMs != '0);
  assign lastStep    = (idx == IDX_W'(LAST_STEP));
  assign byteOut     = curStep.val;
  assign isData      = curStep.isData;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= CNT_W'(RST_CYC - 1);
    end else if (strb.loadRst) begin
      cnt <= CNT_W'(RST_CYC - 1);
    end else if (strb.loadStep) begin
      cnt <= CNT_W'(int'(curStep.waitMs) * CYC_PER_MS - 1);
    end else if (!cntZero) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || strb.clrIdx) begin
      idx <= '0;
    end else if (strb.advIdx && !lastStep) begin
      idx <= idx + 1'b1;
    end
  end

  // R2
  rst_len_chk: assert property (@(posedge clk) disable iff (rst)
    strb.loadRst |=> cnt == CNT_W'(RST_CYC - 1));

  // R9
  idx_bound_chk: assert property (@(posedge clk) disable iff (rst)
    idx <= IDX_W'(LAST_STEP));

endmodule

// File: rtl/lcd_init_ctrl.sv
module lcd_init_ctrl
  import lcd_init_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       byteReady,
  input  logic       cntZero,
  input  logic       stepHasWait,
  input  logic       lastStep,
  output seqStrobe_t strb,
  output logic       byteValid,
  output logic       panelRstN,
  output logic       csN,
  output logic       done
);

  seqState_t state, nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= S_RST;
    else     state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    case (state)
      S_RST:  if (cntZero) nextState = S_SEND;
      S_SEND: if (byteReady) begin
                if (lastStep) begin
                  nextState = S_DONE;
                end else begin
                  strb.advIdx = 1'b1;
                  if (stepHasWait) begin
                    strb.loadStep = 1'b1;
                    nextState     = S_WAIT;
                  end
                end
              end
      S_WAIT: if (cntZero) nextState = S_SEND;
      S_DONE: if (start) begin
                strb.loadRst = 1'b1;
                strb.clrIdx  = 1'b1;
                nextState    = S_RST;
              end
      default: nextState = S_RST;
    endcase
  end

  assign byteValid = !rst && (state == S_SEND);
  assign panelRstN = !rst && (state != S_RST);
  assign csN       = rst || (state == S_RST) || (state == S_DONE);
  assign done      = !rst && (state == S_DONE);

  // R3
  cs_on_release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(panelRstN) |-> !csN);

  // R10
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);

  // R10
  done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    (byteValid && byteReady && lastStep) |=> (done && csN));

endmodule

// File: rtl/lcd_init_seq.sv
module lcd_init_seq
  import lcd_init_pkg::*;
#(
  parameter int CYC_PER_MS = 50000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [1:0] panelType,
  input  logic       byteReady,
  output logic       byteValid,
  output logic [7:0] byteOut,
  output logic       isData,
  output logic       panelRstN,
  output logic       csN,
  output logic       done
);

  seqStrobe_t strb;
  logic       cntZero, stepHasWait, lastStep;

  lcd_init_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .byteReady(byteReady),
    .cntZero(cntZero), .stepHasWait(stepHasWait), .lastStep(lastStep),
    .strb(strb), .byteValid(byteValid), .panelRstN(panelRstN),
    .csN(csN), .done(done)
  );

  lcd_init_dp #(.CYC_PER_MS(CYC_PER_MS)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .panelType(panelType),
    .cntZero(cntZero), .stepHasWait(stepHasWait), .lastStep(lastStep),
    .byteOut(byteOut), .isData(isData)
  );

  // R8
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (byteValid && !byteReady) |=> (byteValid && $stable(byteOut) && $stable(isData)));

endmodule

// File: tb/lcd_init_seq_bench.sv
`timescale 1ns/1ps
module lcd_init_seq_bench;

  localparam int CPM = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [1:0] panelType = 2'd1;
  logic       byteReady = 1'b1;
  logic       byteValid, isData, panelRstN, csN, done;
  logic [7:0] byteOut;

  int vecCount  = 0;
  int failCount = 0;
  int stallMode = 0;
  int cyc = 0;

  logic [8:0] got [0:31];
  int gapLow [0:31];
  int nGot, rstLowCnt, csBad;

  lcd_init_seq #(.CYC_PER_MS(CPM)) u_lcd_init_seq (
    .clk(clk), .rst(rst), .start(start), .panelType(panelType),
    .byteReady(byteReady), .byteValid(byteValid), .byteOut(byteOut),
    .isData(isData), .panelRstN(panelRstN), .csN(csN), .done(done)
  );

  always #2 clk = ~clk;

  initial forever begin
    @(posedge clk);
    #1;
    cyc++;
    byteReady = (stallMode == 0) ? 1'b1 : ((cyc % 3) != 0);
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (!panelRstN) begin
        rstLowCnt++;
        if (!csN) csBad++;
      end
      if (byteValid && byteReady) begin
        if (nGot < 32) got[nGot] = {isData, byteOut};
        nGot++;
        if (csN) csBad++;
      end else if (!csN && !byteValid && nGot > 0 && nGot <= 32) begin
        gapLow[nGot-1]++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vecCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearMon();
    nGot = 0; rstLowCnt = 0; csBad = 0;
    for (int i = 0; i < 32; i++) begin gapLow[i] = 0; got[i] = '0; end
  endtask

  task automatic pulseStart();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic waitDone();
    int n = 0;
    @(negedge clk);
    while (!done && n < 3000) begin @(negedge clk); n++; end
  endtask

  task automatic checkSeq(input logic [1:0] ptype);
    logic [8:0] exp [0:16];
    logic [7:0] orient;
    orient = (ptype == 2'd1) ? 8'h60 : (ptype == 2'd2) ? 8'h00 : 8'hA0;
    exp = '{9'h036, {1'b1, orient}, 9'h02A, 9'h100, 9'h100, 9'h100, 9'h1A0,
            9'h02B, 9'h100, 9'h100, 9'h100, 9'h180, 9'h03A, 9'h105,
            9'h011, 9'h029, 9'h02C};
    check(nGot == 17, "R9 byte count", nGot, 17);
    for (int i = 0; i < 17; i++) begin
      if (i == 1)            check(got[i] == exp[i], "R4 orientation", got[i], exp[i]);
      else if (i < 12)       check(got[i] == exp[i], "R5 window", got[i], exp[i]);
      else if (i < 14)       check(got[i] == exp[i], "R6 format", got[i], exp[i]);
      else                   check(got[i] == exp[i], "R7 wake/on", got[i], exp[i]);
    end
    check(rstLowCnt == 20*CPM, "R2 reset low length", rstLowCnt, 20*CPM);
    check(csBad == 0, "R3 chip select window", csBad, 0);
    check(gapLow[13] == 10*CPM, "R6 format wait", gapLow[13], 10*CPM);
    check(gapLow[14] == 120*CPM, "R7 wake wait", gapLow[14], 120*CPM);
    for (int i = 0; i < 16; i++)
      if (i != 13 && i != 14) check(gapLow[i] == 0, "R9 no extra gap", gapLow[i], 0);
    check(done && csN && panelRstN, "R10 done after last", {done, csN, panelRstN}, 3'b111);
  endtask

  task automatic testReset();
    panelType = 2'd1; stallMode = 0;
    @(negedge clk);
    check(csN && !panelRstN && !byteValid && !done, "R1 reset state",
          {csN, panelRstN, byteValid, done}, 4'b1000);
    clearMon();
    @(posedge clk); #1 rst = 1'b0;
    waitDone();
    checkSeq(2'd1);
  endtask

  task automatic testStallType2();
    panelType = 2'd2; stallMode = 1;
    clearMon();
    pulseStart();
    @(negedge clk);
    check(!done, "R10 start clears done", done, 0);
    waitDone();
    checkSeq(2'd2);
  endtask

  task automatic testIgnoredStart();
    panelType = 2'd3; stallMode = 0;
    clearMon();
    pulseStart();
    while (nGot < 5) @(negedge clk);
    pulseStart();
    waitDone();
    check(nGot == 17 && rstLowCnt == 20*CPM, "R11 start ignored", nGot, 17);
    checkSeq(2'd3);
  endtask

  task automatic testType0();
    panelType = 2'd0; stallMode = 1;
    clearMon();
    pulseStart();
    waitDone();
    checkSeq(2'd0);
    repeat (5) @(negedge clk);
    check(done, "R10 done held", done, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    testReset();
    testStallType2();
    testIgnoredStart();
    testType0();
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

  initial begin
    #(200000 * 4);
    failCount++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

endmodule